// File: doc/BRIEF.md
# Serial-Loaded Segmented Converter Input Register

This block is the digital front end of a 12-bit voltage-output converter. A host writes a code over a three-wire serial link: an active-low select, a serial clock and a data line. The three pins are brought into the system clock domain through two-flop synchronizers, and their edges are found there. Each rising serial clock edge seen while select is low moves one data bit into a shift register, most significant bit first. When select returns high, the shift register contents are copied into a holding register.

The holding register feeds the analog array in segmented form. Its upper three bits become a seven-line thermometer code of equally weighted segments. Its lower nine bits drive the binary-weighted part unchanged. The code is offset binary: 0x800 means zero output, 0xFFF means positive full scale less one step, and 0x000 means negative full scale. Reset presets the holding register to midscale, so the output starts at zero volts.

The held code leaves the block as a stream with a valid strobe and no ready. `upd_o` pulses for exactly one cycle each time a new code is written, and it stays low for the reset preset. The analog array cannot push back, so the sink must take every strobed word in the cycle it appears. A later word may follow after one full serial frame. The system clock must run at least four times as fast as the serial clock.

Top module: `dac_serial_front`

## Requirements
- R1: While and after reset, `code_o` is 0x800, `therm_o` is 7'b0001111, `bin_o` is 0, and `upd_o` does not pulse.
- R2: A frame of exactly 12 rising serial clock edges with select low, data taken MSB first, followed by select rising, leaves that 12-bit word in `code_o`.
- R3: Serial clock edges while select is high do not change the shift register. This is seen at the ports when a following frame with no clock edges latches the earlier contents unchanged.
- R4: The holding register changes only on a rising select edge, and stays constant while a frame is being shifted in.
- R5: If select is held low through reset and a word is then shifted in, `code_o` stays 0x800 until select rises.
- R6: `therm_o` has its lowest n lines high and the others low, where n is the value of `code_o[11:9]` and bit 0 is the lowest line.
- R7: `bin_o` equals `code_o[8:0]`.
- R8: A frame of more than 12 clock edges latches only the last 12 bits shifted in.
- R9: A frame of fewer than 12 clock edges latches the shift register as it stands: the earlier contents moved up by the number of new bits, with the new bits at the bottom.
- R10: `upd_o` is high for exactly one cycle per holding register write.
- R11: A serial clock rising edge that reaches the synchronized domain in the same cycle as the select rise is not shifted in. The latch takes the contents from before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial select, active low; a rising edge latches the word |
| sclk | input | 1 | Serial clock; data captured on its rising edge |
| sdi | input | 1 | Serial data, MSB first |
| code_o | output | 12 | Held offset-binary code |
| therm_o | output | 7 | Thermometer lines for the upper segment |
| bin_o | output | 9 | Binary bits for the lower section |
| upd_o | output | 1 | One-cycle strobe marking a new held code |

## Verification
Capturing a data bit and latching the word can both fall in the same system cycle. This happens when the last serial clock rise and the select release reach the synchronizers together. The bench provokes it by driving both pins high at the same moment. It then judges that the held code equals the shift contents from before that final edge, with the edge dropped. It also checks that the next frame builds on those contents and not on a shifted copy.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
  localparam int WORD_W  = 12;
  localparam int SEG_W   = 3;
  localparam int BIN_W   = WORD_W - SEG_W;
  localparam int THERM_W = (1 << SEG_W) - 1;
  localparam logic [WORD_W-1:0] MIDSCALE = {1'b1, {(WORD_W-1){1'b0}}};

  // n -> lowest n lines set
  function automatic logic [THERM_W-1:0] to_therm(input logic [SEG_W-1:0] v);
    logic [THERM_W-1:0] t;
    for (int i = 0; i < THERM_W; i++) t[i] = (i < int'(v));
    return t;
  endfunction
endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[s] <= RST_VAL;
        else        stg[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[s] <= RST_VAL;
        else        stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/dacfe_shift.sv
module dacfe_shift #(
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_s,
  input  logic              sclk_s,
  input  logic              sdi_s,
  output logic [WORD_W-1:0] sr_o,
  output logic              load_o
);
  logic cs_prev, sclk_prev;
  logic sclk_rise;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_prev   <= 1'b1;
      sclk_prev <= 1'b0;
    end else begin
      cs_prev   <= cs_n_s;
      sclk_prev <= sclk_s;
    end

  assign sclk_rise = sclk_s & ~sclk_prev;
  assign load_o    = cs_n_s & ~cs_prev;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                  sr_o <= '0;
    else if (sclk_rise && !cs_n_s) sr_o <= {sr_o[WORD_W-2:0], sdi_s};

  AST_NO_SHIFT_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> $stable(sr_o)); // R3
endmodule

// File: rtl/dacfe_hold.sv
module dacfe_hold
  import dacfe_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int SW = SEG_W,
  parameter int TW = (1 << SW) - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [W-1:0]  word_i,
  output logic [W-1:0]  code_o,
  output logic [TW-1:0] therm_o,
  output logic [W-SW-1:0] bin_o,
  output logic          upd_o
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      code_o <= {1'b1, {(W-1){1'b0}}};
      upd_o  <= 1'b0;
    end else begin
      upd_o <= load_i;
      if (load_i) code_o <= word_i;
    end

  always_comb
    for (int i = 0; i < TW; i++) therm_o[i] = (i < int'(code_o[W-1 -: SW]));

  assign bin_o = code_o[W-SW-1:0];

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(code_o)); // R4
  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |=> !upd_o); // R10
  AST_THERM_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (therm_o & (therm_o + {{(TW-1){1'b0}}, 1'b1})) == '0); // R6
  AST_THERM_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(therm_o) == int'(code_o[W-1 -: SW])); // R6
endmodule

// File: rtl/dac_serial_front.sv
module dac_serial_front
  import dacfe_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               sclk,
  input  logic               sdi,
  output logic [WORD_W-1:0]  code_o,
  output logic [THERM_W-1:0] therm_o,
  output logic [BIN_W-1:0]   bin_o,
  output logic               upd_o
);
  logic [2:0]        pins_s;
  logic [WORD_W-1:0] sr;
  logic              load;

  dacfe_sync #(.W(3), .STAGES(2), .RST_VAL(3'b001)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i({sdi, sclk, cs_n}), .q_o(pins_s)
  );

  dacfe_shift #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .cs_n_s(pins_s[0]), .sclk_s(pins_s[1]),
    .sdi_s(pins_s[2]), .sr_o(sr), .load_o(load)
  );

  dacfe_hold #(.W(WORD_W), .SW(SEG_W), .TW(THERM_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .load_i(load), .word_i(sr),
    .code_o(code_o), .therm_o(therm_o), .bin_o(bin_o), .upd_o(upd_o)
  );
endmodule

// File: tb/tb_dac_serial_front.sv
module tb_dac_serial_front;
  localparam int CLK_P = 10;
  localparam int HALF  = 3;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic [11:0] code_o;
  logic [6:0]  therm_o;
  logic [8:0]  bin_o;
  logic        upd_o;

  int checks = 0, fails = 0, upd_cnt = 0, exp_upd = 0;
  logic [11:0] m_sr = '0, m_held = 12'h800;

  dac_serial_front dut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .code_o(code_o), .therm_o(therm_o), .bin_o(bin_o), .upd_o(upd_o));

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) if (rst_n && upd_o) upd_cnt++;

  // {bit count, data right-aligned}
  localparam logic [20:0] VEC [0:7] = '{
    {5'd12, 16'h0FFF}, {5'd12, 16'h0000}, {5'd12, 16'h0800}, {5'd12, 16'h07FF},
    {5'd12, 16'h0A5C}, {5'd14, 16'h3ABC}, {5'd5,  16'h0013}, {5'd12, 16'h0201}};

  task automatic wcyc(input int n); repeat (n) @(negedge clk); endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] therm_of(input logic [2:0] n);
    return 7'h7F >> (7 - int'(n));
  endfunction

  task automatic send_bits(input logic [15:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = v[i]; wcyc(HALF);
      sclk = 1'b1; if (!cs_n) m_sr = {m_sr[10:0], v[i]};
      wcyc(HALF); sclk = 1'b0;
    end
  endtask

  task automatic frame(input logic [15:0] v, input int n);
    cs_n = 1'b0; wcyc(HALF); send_bits(v, n); wcyc(HALF);
    cs_n = 1'b1; wcyc(6); m_held = m_sr; exp_upd++;
  endtask

  task automatic check_out(input string tag);
    check({tag, " code"}, 32'(code_o), 32'(m_held));
    check("R6 therm", 32'(therm_o), 32'(therm_of(m_held[11:9])));
    check("R7 bin", 32'(bin_o), 32'(m_held[8:0]));
    check("R10 strobe count", 32'(upd_cnt), 32'(exp_upd));
  endtask

  initial begin
    #(CLK_P * 150000);
    fails++; $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wcyc(4);
    check("R1 code in reset", 32'(code_o), 32'h800);
    rst_n = 1'b1; wcyc(4);
    check("R1 code", 32'(code_o), 32'h800);
    check("R1 therm", 32'(therm_o), 32'h0F);
    check("R1 bin", 32'(bin_o), 32'h0);
    check("R1 no strobe", 32'(upd_cnt), 32'h0);

    for (int k = 0; k < 8; k++) begin
      frame(VEC[k][15:0], int'(VEC[k][20:16]));
      check_out(k == 5 ? "R8" : (k == 6 ? "R9" : "R2"));
    end

    // R4: held constant mid-frame
    cs_n = 1'b0; wcyc(HALF); send_bits(16'h05A, 6);
    check("R4 mid-frame", 32'(code_o), 32'(m_held));
    send_bits(16'h03C, 6); wcyc(HALF); cs_n = 1'b1; wcyc(6);
    m_held = m_sr; exp_upd++; check_out("R4");

    // R3: clocks while select high ignored
    send_bits(16'hFFFF, 5);
    check("R3 held", 32'(code_o), 32'(m_held));
    frame(16'h0, 0);
    check_out("R3");

    // R11: last clock rise together with select release
    cs_n = 1'b0; wcyc(HALF); send_bits(16'h0155, 11);
    sdi = 1'b1; wcyc(HALF);
    sclk = 1'b1; cs_n = 1'b1; wcyc(6); sclk = 1'b0; wcyc(2);
    m_held = m_sr; exp_upd++;
    check_out("R11");
    frame(16'h1, 1);
    check_out("R11 follow");

    // R5: select low through reset
    rst_n = 1'b0; cs_n = 1'b0; wcyc(3);
    upd_cnt = 0; exp_upd = 0; m_sr = '0; m_held = 12'h800;
    rst_n = 1'b1; wcyc(3);
    send_bits(16'h0123, 12); wcyc(HALF);
    check("R5 midscale held", 32'(code_o), 32'h800);
    check("R5 no strobe", 32'(upd_cnt), 32'h0);
    cs_n = 1'b1; wcyc(6); m_held = m_sr; exp_upd++;
    check_out("R5");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule